// File: doc/BRIEF.md
# Two-Channel PWM Brake Controller

This block sits between a PWM waveform generator and its output pins and forces both channels to a safe level when a fault is reported. There are two fault inputs. A rising edge on the edge-triggered input latches a brake on both channels. That brake holds until software acknowledges it per channel. A high level on the level-triggered input holds both channels in brake for as long as the input stays high.

Leaving a brake is never immediate. The generator supplies a one-cycle strobe at the end of each PWM period. A channel is released at the clock edge that samples that strobe, so its raw waveform comes back on the first cycle of a fresh period.

Software sees one 32-bit status word. It holds four write-1-to-clear interrupt flags and four read-only brake state bits. Any pending flag drives the interrupt output.

Top module: `pwm_brake_ctl`

## Requirements
- R1: After reset, `reg_rdata` reads 0, `irq` is low and each `pwm_out` bit follows its `pwm_raw` bit.
- R2: A 0-to-1 transition of `brk_edge_in` sets the edge flags (bits 0 and 1 for channels 0 and 1) and the edge brake states (bits 16 and 17) at the same clock edge. Holding the input high does not count as a new transition.
- R3: A channel's edge brake state (bit 16 + channel) stays set while its edge flag is set. Once the flag is 0, the state clears at the clock edge that samples `period_end` high.
- R4: A write with `reg_wr` high clears each flag whose `reg_wdata` bit is 1. Flags written with 0 are unchanged, and brake state bits cannot be written.
- R5: While `brk_level_in` is high, the level flags (bits 8 and 9) and the level brake states (bits 24 and 25) are set. Once the input is low, both level brake states clear together at the clock edge that samples `period_end` high.
- R6: A level flag write-1-to-clear has no effect while `brk_level_in` is high.
- R7: When an edge-flag clear and a 0-to-1 transition of `brk_edge_in` arrive in the same cycle, the flag and the brake state stay set.
- R8: While either brake state bit of a channel is set, `pwm_out` for that channel equals bit `channel` of `SAFE_LVL`. Otherwise it equals `pwm_raw`.
- R9: `irq` is high exactly when any of bits 0, 1, 8 or 9 is set.
- R10: Bits other than 0, 1, 8, 9, 16, 17, 24 and 25 always read 0. Writing 1 to them changes nothing.
- R11: A `period_end` pulse while a channel's edge flag is still set leaves that channel braked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| period_end | input | 1 | One-cycle strobe at the last cycle of each PWM period |
| brk_edge_in | input | 1 | Edge-triggered fault input (rising edge acts) |
| brk_level_in | input | 1 | Level-triggered fault input (high acts) |
| pwm_raw | input | 2 | Raw waveforms from the PWM generator, one bit per channel |
| reg_wr | input | 1 | Write strobe for the status word |
| reg_wdata | input | 32 | Write data; 1 bits clear the matching flags |
| reg_rdata | output | 32 | Status word: flags and brake states |
| pwm_out | output | 2 | Gated channel outputs |
| irq | output | 1 | High while any flag is pending |

## Verification
The hardest situations to reach are the races. One is a flag clear landing in the same cycle as a new edge fault. Another is a flag clear landing in the same cycle as a period strobe; there the channel must stay braked for one more period. Both come only from placing a write, a strobe and an input transition in exactly one chosen cycle. The bench drives every input at a falling edge per cycle and builds these collisions deliberately. It then adds a long stretch of random strobes, writes and fault transitions, checked against a model written from the requirements.

// File: rtl/pwm_brake_pkg.sv
package pwm_brake_pkg;
  localparam int unsigned NCH       = 2;
  localparam int unsigned REG_W     = 32;
  localparam int unsigned EFLAG_LSB = 0;
  localparam int unsigned LFLAG_LSB = 8;
  localparam int unsigned ESTAT_LSB = 16;
  localparam int unsigned LSTAT_LSB = 24;
endpackage

// File: rtl/brk_edge_chan.sv
module brk_edge_chan (
  input  logic clk,
  input  logic rst_n,
  input  logic rise_i,
  input  logic clr_i,
  input  logic period_end_i,
  output logic flag_o,
  output logic stat_o
);
  logic flag_q, flag_d;
  logic stat_q, stat_d;
  logic upd;

  always_comb begin
    flag_d = flag_q;
    stat_d = stat_q;
    if (rise_i) begin
      flag_d = 1'b1;
      stat_d = 1'b1;
    end else begin
      if (clr_i) flag_d = 1'b0;
      if (stat_q && !flag_q && period_end_i) stat_d = 1'b0;
    end
  end

  assign upd = (flag_d != flag_q) || (stat_d != stat_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      stat_q <= 1'b0;
    end else if (upd) begin
      flag_q <= flag_d;
      stat_q <= stat_d;
    end
  end

  assign flag_o = flag_q;
  assign stat_o = stat_q;

  p_edge_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rise_i |=> (flag_o && stat_o));
  p_flag_holds_brake_r3: assert property (@(posedge clk) disable iff (!rst_n)
    flag_o |=> stat_o);
  p_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_o && !flag_o && period_end_i && !rise_i) |=> !stat_o);
  p_race_new_event_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_i && clr_i) |=> flag_o);
endmodule

// File: rtl/brk_level_ctl.sv
module brk_level_ctl
  import pwm_brake_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           level_i,
  input  logic           period_end_i,
  input  logic [NCH-1:0] clr_i,
  output logic [NCH-1:0] flag_o,
  output logic [NCH-1:0] stat_o
);
  logic [NCH-1:0] flag_q, flag_d;
  logic           stat_q, stat_d;

  always_comb begin
    flag_d = flag_q;
    if (level_i) flag_d = '1;
    else         flag_d = flag_q & ~clr_i;
    stat_d = stat_q;
    if (level_i)           stat_d = 1'b1;
    else if (period_end_i) stat_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= '0;
      stat_q <= 1'b0;
    end else begin
      flag_q <= flag_d;
      stat_q <= stat_d;
    end
  end

  assign flag_o = flag_q;
  assign stat_o = {NCH{stat_q}};

  p_level_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    level_i |=> ((&flag_o) && (&stat_o)));
  p_level_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!level_i && period_end_i) |=> !(|stat_o));
  p_level_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((|stat_o) && !period_end_i) |=> (&stat_o));
  p_lflag_w1c_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!level_i && clr_i[0]) |=> !flag_o[0]);
endmodule

// File: rtl/brk_regif.sv
module brk_regif
  import pwm_brake_pkg::*;
(
  input  logic             wr_i,
  input  logic [REG_W-1:0] wdata_i,
  input  logic [NCH-1:0]   eflag_i,
  input  logic [NCH-1:0]   lflag_i,
  input  logic [NCH-1:0]   estat_i,
  input  logic [NCH-1:0]   lstat_i,
  output logic [NCH-1:0]   eclr_o,
  output logic [NCH-1:0]   lclr_o,
  output logic [REG_W-1:0] rdata_o
);
  localparam logic [REG_W-1:0] CLR_MASK =
    (REG_W'((1 << NCH) - 1) << EFLAG_LSB) | (REG_W'((1 << NCH) - 1) << LFLAG_LSB);

  logic unused_wbits;
  assign unused_wbits = ^(wdata_i & ~CLR_MASK);

  always_comb begin
    rdata_o = '0;
    for (int c = 0; c < NCH; c++) begin
      eclr_o[c] = wr_i && wdata_i[EFLAG_LSB + c];
      lclr_o[c] = wr_i && wdata_i[LFLAG_LSB + c];
      rdata_o[EFLAG_LSB + c] = eflag_i[c];
      rdata_o[LFLAG_LSB + c] = lflag_i[c];
      rdata_o[ESTAT_LSB + c] = estat_i[c];
      rdata_o[LSTAT_LSB + c] = lstat_i[c];
    end
  end
endmodule

// File: rtl/pwm_brake_ctl.sv
module pwm_brake_ctl
  import pwm_brake_pkg::*;
#(
  parameter logic [NCH-1:0] SAFE_LVL = 2'b10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             period_end,
  input  logic             brk_edge_in,
  input  logic             brk_level_in,
  input  logic [NCH-1:0]   pwm_raw,
  input  logic             reg_wr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  output logic [NCH-1:0]   pwm_out,
  output logic             irq
);
  logic [1:0]     rst_pipe;
  logic           srst_n;
  logic           edge_q;
  logic           rise;
  logic [NCH-1:0] eflag, estat, lflag, lstat, eclr, lclr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign srst_n = rst_pipe[1];

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) edge_q <= 1'b0;
    else         edge_q <= brk_edge_in;
  end
  assign rise = brk_edge_in && !edge_q;

  brk_regif u_regif (
    .wr_i    (reg_wr),
    .wdata_i (reg_wdata),
    .eflag_i (eflag),
    .lflag_i (lflag),
    .estat_i (estat),
    .lstat_i (lstat),
    .eclr_o  (eclr),
    .lclr_o  (lclr),
    .rdata_o (reg_rdata)
  );

  brk_level_ctl u_level (
    .clk          (clk),
    .rst_n        (srst_n),
    .level_i      (brk_level_in),
    .period_end_i (period_end),
    .clr_i        (lclr),
    .flag_o       (lflag),
    .stat_o       (lstat)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    brk_edge_chan u_edge (
      .clk          (clk),
      .rst_n        (srst_n),
      .rise_i       (rise),
      .clr_i        (eclr[c]),
      .period_end_i (period_end),
      .flag_o       (eflag[c]),
      .stat_o       (estat[c])
    );

    assign pwm_out[c] = (estat[c] || lstat[c]) ? SAFE_LVL[c] : pwm_raw[c];

    p_out_safe_r8: assert property (@(posedge clk) disable iff (!srst_n)
      (reg_rdata[ESTAT_LSB + c] || reg_rdata[LSTAT_LSB + c]) |-> (pwm_out[c] == SAFE_LVL[c]));
  end

  assign irq = (|eflag) || (|lflag);

  p_irq_r9: assert property (@(posedge clk) disable iff (!srst_n)
    irq |-> ((reg_rdata[EFLAG_LSB +: NCH] != '0) || (reg_rdata[LFLAG_LSB +: NCH] != '0)));
  p_reserved_zero_r10: assert property (@(posedge clk) disable iff (!srst_n)
    (reg_rdata & ~((REG_W'((1 << NCH) - 1) << EFLAG_LSB) | (REG_W'((1 << NCH) - 1) << LFLAG_LSB) |
                   (REG_W'((1 << NCH) - 1) << ESTAT_LSB) | (REG_W'((1 << NCH) - 1) << LSTAT_LSB))) == '0);
endmodule

// File: tb/test_pwm_brake_ctl.sv
`timescale 1ns/1ps
module test_pwm_brake_ctl;
  localparam logic [1:0] SAFE = 2'b10;

  typedef struct {
    string       tag;
    logic [31:0] rd;
    logic [1:0]  out;
    logic        irq;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic period_end = 1'b0, brk_edge_in = 1'b0, brk_level_in = 1'b0, reg_wr = 1'b0;
  logic [1:0] pwm_raw = 2'b00;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [1:0] pwm_out;
  logic irq;

  exp_t q[$];
  int checks = 0, errors = 0;
  bit done = 0;

  logic [1:0] m_ef = '0, m_es = '0, m_lf = '0;
  logic m_ls = 1'b0, m_prev = 1'b0;

  always #2 clk = ~clk;

  pwm_brake_ctl #(.SAFE_LVL(SAFE)) i_pwm_brake_ctl (
    .clk(clk), .rst_n(rst_n), .period_end(period_end), .brk_edge_in(brk_edge_in),
    .brk_level_in(brk_level_in), .pwm_raw(pwm_raw), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .pwm_out(pwm_out), .irq(irq)
  );

  task automatic step(input string tag, input logic pe, input logic eg, input logic lv,
                      input logic [1:0] raw, input logic wr, input logic [31:0] wd);
    exp_t e;
    logic rise;
    logic [1:0] nef, nes, nlf;
    logic nls;
    @(negedge clk);
    period_end = pe; brk_edge_in = eg; brk_level_in = lv;
    pwm_raw = raw; reg_wr = wr; reg_wdata = wd;
    rise = eg && !m_prev;
    for (int c = 0; c < 2; c++) begin
      nef[c] = rise ? 1'b1 : ((wr && wd[c]) ? 1'b0 : m_ef[c]);
      nes[c] = rise ? 1'b1 : ((m_es[c] && !m_ef[c] && pe) ? 1'b0 : m_es[c]);
      nlf[c] = lv ? 1'b1 : ((wr && wd[8+c]) ? 1'b0 : m_lf[c]);
    end
    nls = lv ? 1'b1 : (pe ? 1'b0 : m_ls);
    m_ef = nef; m_es = nes; m_lf = nlf; m_ls = nls; m_prev = eg;
    e.tag = tag;
    e.rd = '0;
    e.rd[1:0] = m_ef; e.rd[9:8] = m_lf; e.rd[17:16] = m_es; e.rd[25:24] = {m_ls, m_ls};
    for (int c = 0; c < 2; c++) e.out[c] = (m_es[c] || m_ls) ? SAFE[c] : raw[c];
    e.irq = (|m_ef) || (|m_lf);
    q.push_back(e);
  endtask

  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (reg_rdata !== e.rd || pwm_out !== e.out || irq !== e.irq) begin
        errors++;
        $display("FAIL %s: rdata=%h out=%b irq=%b expected rdata=%h out=%b irq=%b",
                 e.tag, reg_rdata, pwm_out, irq, e.rd, e.out, e.irq);
      end
    end
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic eg_r;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state, outputs follow raw
    step("R1", 0, 0, 0, 2'b00, 0, '0);
    step("R1", 0, 0, 0, 2'b01, 0, '0);
    step("R8", 0, 0, 0, 2'b10, 0, '0);
    // R2 edge fault sets flags and states; held high is no new edge
    step("R2", 0, 1, 0, 2'b01, 0, '0);
    step("R2", 0, 1, 0, 2'b11, 0, '0);
    step("R8", 0, 1, 0, 2'b00, 0, '0);
    // R4 writing 0 does nothing; R10 reserved bits
    step("R4", 0, 1, 0, 2'b01, 1, 32'h0000_0000);
    step("R10", 0, 1, 0, 2'b01, 1, ~32'h0000_0303);
    step("R4", 0, 1, 0, 2'b01, 1, 32'h0303_0000);
    // R11 strobe while flag set keeps brake
    step("R11", 1, 1, 0, 2'b11, 0, '0);
    // R3 clear channel 0 flag, then strobe releases channel 0 only
    step("R3", 0, 1, 0, 2'b11, 1, 32'h0000_0001);
    step("R3", 0, 1, 0, 2'b11, 0, '0);
    step("R3", 1, 1, 0, 2'b11, 0, '0);
    step("R3", 0, 1, 0, 2'b01, 0, '0);
    // R7 clear and new edge in the same cycle
    step("R7", 0, 0, 0, 2'b01, 0, '0);
    step("R7", 0, 1, 0, 2'b01, 1, 32'h0000_0003);
    step("R7", 0, 1, 0, 2'b01, 0, '0);
    // R3 clear in the same cycle as strobe: one more period braked
    step("R3", 1, 1, 0, 2'b01, 1, 32'h0000_0003);
    step("R3", 0, 1, 0, 2'b01, 0, '0);
    step("R3", 1, 1, 0, 2'b01, 0, '0);
    step("R9", 0, 1, 0, 2'b01, 0, '0);
    // R5 level fault; R6 clear ignored while high
    step("R5", 0, 1, 1, 2'b10, 0, '0);
    step("R6", 0, 1, 1, 2'b10, 1, 32'h0000_0300);
    step("R5", 1, 1, 1, 2'b10, 0, '0);
    step("R5", 0, 1, 0, 2'b01, 0, '0);
    step("R6", 0, 1, 0, 2'b01, 1, 32'h0000_0100);
    step("R9", 0, 1, 0, 2'b01, 1, 32'h0000_0200);
    step("R5", 1, 1, 0, 2'b01, 0, '0);
    step("R5", 0, 1, 0, 2'b10, 0, '0);
    // R8 randomized mix against the model
    eg_r = 1'b1;
    for (int i = 0; i < 400; i++) begin
      logic [31:0] r;
      r = $urandom;
      if (r[3:1] == 3'd0) eg_r = ~eg_r;
      step("R8", r[5:4] == 2'd0, eg_r, r[9:7] == 3'd0, r[11:10],
           r[13:12] == 2'd0, {r[31:24] & 8'h03, 8'h00, r[23:16], r[15:14], 6'h00, r[17:16]});
    end
    step("R9", 0, 0, 0, 2'b00, 1, 32'h0000_0303);
    step("R9", 1, 0, 0, 2'b00, 0, '0);
    step("R9", 1, 0, 0, 2'b01, 0, '0);
    step("R1", 0, 0, 0, 2'b10, 0, '0);
    repeat (3) @(negedge clk);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule